// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

If an I2C transfer is cut short, a slave can be left in the middle of a byte with SDA held low, and the bus stays unusable. This sequencer clears that condition before the bus master is (re)initialised. Once a start request arrives, it waits a bounded time for the controller's busy indication to drop. If busy is still set when that wait runs out, or if the synchronised SDA level is low, it takes both pins away from the controller and clocks SCL itself. The stuck slave can then finish shifting and let go of SDA.

The first recovery step holds SCL low for one half-period. After that the sequencer issues high/low clock pulses. SDA is sampled at the end of every low half-period, and the sequence ends as soon as SDA reads high or a pulse limit is reached. SCL is then held high for one last half-period and the pins are handed back. A one-cycle done pulse reports the end of the sequence. If SDA was still low at the last check, a held failure flag is also set. Generating a STOP condition is left to the controller.

Top module: `i2c_unstick_seq`

## Requirements
- R1: After reset, scl_drive is 1, and pin_override, seq_done and seq_fail are all 0.
- R2: A start_req that arrives while a sequence is in progress is ignored: each accepted start gives exactly one seq_done pulse, and no second sequence follows.
- R3: The cycle after the start is accepted, the block polls bus_busy. If bus_busy is 0 and the synchronised SDA is high, the sequence ends with seq_done on the next cycle and pin_override is never raised. If bus_busy drops later in the poll window, seq_done follows on the cycle after the drop.
- R4: The block enters recovery and raises pin_override when either of two conditions holds: bus_busy is still 1 after IDLE_LIMIT poll cycles (pin_override appears IDLE_LIMIT+1 cycles after the start is accepted), or bus_busy is 0 while SDA, passed through SYNC_STAGES flops, reads low (pin_override appears 2 cycles after the start is accepted).
- R5: Recovery first drives SCL low (scl_drive=0) for exactly HALF_TICKS cycles, before SDA is checked.
- R6: Each clock pulse is HALF_TICKS cycles high followed by HALF_TICKS cycles low. SDA is checked at the end of each low half-period, and recovery stops at the first check that finds SDA high, so a slave that releases on its k-th rising edge receives exactly k pulses.
- R7: At most MAX_PULSES pulses are issued. If SDA is still low at the check after the last pulse, seq_fail is set in the same cycle as seq_done.
- R8: Recovery ends with SCL high for HALF_TICKS cycles. pin_override then falls in the same cycle that seq_done rises.
- R9: seq_done lasts exactly one cycle. seq_fail holds its value until the next start is accepted, and it clears on the cycle after that start.
- R10: Whenever pin_override is 0, scl_drive is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request to check the bus and recover it if needed |
| bus_busy | input | 1 | Busy indication from the bus controller |
| sda_in | input | 1 | Raw SDA pin level (asynchronous) |
| scl_drive | output | 1 | SCL level under direct control: 1 releases the line high, 0 pulls it low |
| pin_override | output | 1 | 1 selects direct pin control in place of the controller |
| seq_done | output | 1 | One-cycle pulse at the end of each accepted sequence |
| seq_fail | output | 1 | SDA still low after the last allowed pulse; held until the next start |

## Verification
Take the cycle in which start_req is first seen as cycle 0. Done for a clean bus is due in cycle 2, measured at the falling edge. Pin override is due in cycle 2 when SDA is stuck, or in cycle IDLE_LIMIT+1 when busy never drops. The pin-override interval lasts HALF_TICKS*(2k+2) cycles for k pulses. Done falls in the cycle right after the override interval ends, and when busy drops during polling, done comes one cycle after the drop. The bench drives stimulus on falling edges, samples outputs on falling edges, and counts those edges from the start request. A monitor measures the length of every SCL level run while override is active and compares each one with HALF_TICKS, and it counts rising SCL edges to derive the number of pulses.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;

   typedef enum logic [2:0] {
      UST_IDLE,
      UST_POLL,
      UST_LOW,
      UST_HIGH,
      UST_LAST
   } ust_state_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/i2c_unstick_sync.sv
module i2c_unstick_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_unstick_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= RESET_VAL;
               else        chain[gi] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= RESET_VAL;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_unstick_halftimer.sv
module i2c_unstick_halftimer #(
   parameter int unsigned HALF_TICKS = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);

   localparam int unsigned    CW     = i2c_unstick_pkg::cnt_width(HALF_TICKS);
   localparam logic [CW-1:0]  RELOAD = CW'(HALF_TICKS - 1);

   generate
      if (HALF_TICKS < 1) begin : g_bad_half
         $error("i2c_unstick_halftimer: HALF_TICKS must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= RELOAD;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/i2c_unstick_ctrl.sv
module i2c_unstick_ctrl
   import i2c_unstick_pkg::*;
#(
   parameter int unsigned IDLE_LIMIT = 1000,
   parameter int unsigned MAX_PULSES = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic bus_busy,
   input  logic sda_s,
   input  logic tmr_expired,
   output logic tmr_load,
   output logic scl_drive,
   output logic pin_override,
   output logic seq_done,
   output logic seq_fail
);

   localparam int unsigned   WW        = cnt_width(IDLE_LIMIT);
   localparam int unsigned   PW        = cnt_width(MAX_PULSES + 1);
   localparam logic [WW-1:0] WAIT_LAST = WW'(IDLE_LIMIT - 1);
   localparam logic [PW-1:0] PULSE_CAP = PW'(MAX_PULSES);

   generate
      if (IDLE_LIMIT < 1) begin : g_bad_idle
         $error("i2c_unstick_ctrl: IDLE_LIMIT must be at least 1");
      end
      if (MAX_PULSES < 1) begin : g_bad_pulses
         $error("i2c_unstick_ctrl: MAX_PULSES must be at least 1");
      end
   endgenerate

   ust_state_e    state, st_n;
   logic [WW-1:0] wait_cnt, wcnt_n;
   logic [PW-1:0] pulse_cnt, pcnt_n;
   logic          fail_pend, pend_n;
   logic          done_q, done_n;
   logic          fail_q, fail_n;

   always_comb begin
      st_n     = state;
      wcnt_n   = wait_cnt;
      pcnt_n   = pulse_cnt;
      pend_n   = fail_pend;
      done_n   = 1'b0;
      fail_n   = fail_q;
      tmr_load = 1'b0;
      unique case (state)
         UST_IDLE: begin
            if (start_req) begin
               st_n   = UST_POLL;
               wcnt_n = '0;
               pend_n = 1'b0;
               fail_n = 1'b0;
            end
         end
         UST_POLL: begin
            if (!bus_busy) begin
               if (sda_s) begin
                  st_n   = UST_IDLE;
                  done_n = 1'b1;
               end else begin
                  st_n     = UST_LOW;
                  pcnt_n   = '0;
                  tmr_load = 1'b1;
               end
            end else if (wait_cnt == WAIT_LAST) begin
               st_n     = UST_LOW;
               pcnt_n   = '0;
               tmr_load = 1'b1;
            end else begin
               wcnt_n = wait_cnt + 1'b1;
            end
         end
         UST_LOW: begin
            if (tmr_expired) begin
               tmr_load = 1'b1;
               if (sda_s) begin
                  st_n = UST_LAST;
               end else if (pulse_cnt == PULSE_CAP) begin
                  st_n   = UST_LAST;
                  pend_n = 1'b1;
               end else begin
                  st_n = UST_HIGH;
               end
            end
         end
         UST_HIGH: begin
            if (tmr_expired) begin
               tmr_load = 1'b1;
               st_n     = UST_LOW;
               pcnt_n   = pulse_cnt + 1'b1;
            end
         end
         UST_LAST: begin
            if (tmr_expired) begin
               st_n   = UST_IDLE;
               done_n = 1'b1;
               fail_n = fail_pend;
            end
         end
         default: st_n = UST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= UST_IDLE;
         wait_cnt  <= '0;
         pulse_cnt <= '0;
         fail_pend <= 1'b0;
         done_q    <= 1'b0;
         fail_q    <= 1'b0;
      end else begin
         state     <= st_n;
         wait_cnt  <= wcnt_n;
         pulse_cnt <= pcnt_n;
         fail_pend <= pend_n;
         done_q    <= done_n;
         fail_q    <= fail_n;
      end
   end

   assign pin_override = (state == UST_LOW) || (state == UST_HIGH) || (state == UST_LAST);
   assign scl_drive    = (state != UST_LOW);
   assign seq_done     = done_q;
   assign seq_fail     = fail_q;

endmodule

// File: rtl/i2c_unstick_seq.sv
module i2c_unstick_seq #(
   parameter int unsigned HALF_TICKS  = 1000,
   parameter int unsigned IDLE_LIMIT  = 200000,
   parameter int unsigned MAX_PULSES  = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic bus_busy,
   input  logic sda_in,
   output logic scl_drive,
   output logic pin_override,
   output logic seq_done,
   output logic seq_fail
);

   logic sda_s;
   logic tmr_load;
   logic tmr_expired;

   i2c_unstick_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sda_in),
      .q     (sda_s)
   );

   i2c_unstick_halftimer #(
      .HALF_TICKS (HALF_TICKS)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .expired (tmr_expired)
   );

   i2c_unstick_ctrl #(
      .IDLE_LIMIT (IDLE_LIMIT),
      .MAX_PULSES (MAX_PULSES)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_req    (start_req),
      .bus_busy     (bus_busy),
      .sda_s        (sda_s),
      .tmr_expired  (tmr_expired),
      .tmr_load     (tmr_load),
      .scl_drive    (scl_drive),
      .pin_override (pin_override),
      .seq_done     (seq_done),
      .seq_fail     (seq_fail)
   );

endmodule

// File: rtl/i2c_unstick_seq_chk.sv
module i2c_unstick_seq_chk #(
   parameter int unsigned MAX_PULSES = 10
) (
   input logic clk,
   input logic rst_n,
   input logic scl_drive,
   input logic pin_override,
   input logic seq_done,
   input logic seq_fail
);

   logic [7:0] rise_cnt;
   logic       scl_prev;
   logic       ovr_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_cnt <= '0;
         scl_prev <= 1'b1;
         ovr_prev <= 1'b0;
      end else begin
         scl_prev <= scl_drive;
         ovr_prev <= pin_override;
         if (pin_override && !ovr_prev)
            rise_cnt <= '0;
         else if (pin_override && scl_drive && !scl_prev && rise_cnt != 8'hFF)
            rise_cnt <= rise_cnt + 1'b1;
      end
   end

   // R10: SCL is released whenever the controller owns the pins
   p_scl_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_override |-> scl_drive);

   // R9: done lasts one cycle
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done);

   // R8: hand-back coincides with done and follows a high SCL phase
   p_release_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pin_override) |-> (seq_done && $past(scl_drive)));

   // R7: failure only appears together with done
   p_fail_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_fail) |-> seq_done);

   // R7: pulse limit plus the final high phase
   p_pulse_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pin_override |-> (int'(rise_cnt) <= MAX_PULSES + 1));

   // R5: recovery opens with SCL low
   p_first_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pin_override) |-> !scl_drive);

endmodule

bind i2c_unstick_seq i2c_unstick_seq_chk #(
   .MAX_PULSES (MAX_PULSES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .scl_drive    (scl_drive),
   .pin_override (pin_override),
   .seq_done     (seq_done),
   .seq_fail     (seq_fail)
);

// File: tb/i2c_unstick_seq_tb.sv
module i2c_unstick_seq_tb;

   localparam int HALF = 4;
   localparam int IDLE = 20;
   localparam int MAXP = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_req = 1'b0;
   logic bus_busy = 1'b0;
   logic slave_hold = 1'b0;
   int   rel_target = 0;
   logic sda_in;
   logic scl_drive, pin_override, seq_done, seq_fail;

   int total = 0;
   int bad = 0;

   int mon_dones = 0;
   int mon_rises = 0;
   int mon_runbad = 0;
   int mon_sclbad = 0;
   int run_len = 0;
   logic prv_scl = 1'b1;
   logic prv_ovr = 1'b0;

   always #2.5ns clk = ~clk;

   assign sda_in = !(slave_hold && (mon_rises < rel_target));

   i2c_unstick_seq #(
      .HALF_TICKS  (HALF),
      .IDLE_LIMIT  (IDLE),
      .MAX_PULSES  (MAXP),
      .SYNC_STAGES (2)
   ) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_req    (start_req),
      .bus_busy     (bus_busy),
      .sda_in       (sda_in),
      .scl_drive    (scl_drive),
      .pin_override (pin_override),
      .seq_done     (seq_done),
      .seq_fail     (seq_fail)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (seq_done) mon_dones++;
         if (!pin_override && !scl_drive) mon_sclbad++;
         if (pin_override && scl_drive && !prv_scl) mon_rises++;
         if (pin_override) begin
            if (prv_ovr && scl_drive == prv_scl) run_len++;
            else begin
               if (prv_ovr && run_len != HALF) mon_runbad++;
               run_len = 1;
            end
         end else if (prv_ovr) begin
            if (run_len != HALF) mon_runbad++;
            run_len = 0;
         end
         prv_scl = scl_drive;
         prv_ovr = pin_override;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_seq(input int inject_at, input int busy_drop_at,
                          output int ovr_at, output int done_at, output int dones,
                          output int rises, output int runbad, output int fail_at_done,
                          output int fail_after_start);
      int r0, b0, d0;
      @(negedge clk);
      r0 = mon_rises; b0 = mon_runbad; d0 = mon_dones;
      start_req = 1'b1;
      ovr_at = -1; done_at = -1; fail_at_done = -1; fail_after_start = -1;
      for (int i = 1; i <= 3000 && done_at < 0; i++) begin
         @(negedge clk);
         start_req = (i == inject_at);
         if (i == busy_drop_at) bus_busy = 1'b0;
         if (i == 1) fail_after_start = int'(seq_fail);
         if (pin_override && ovr_at < 0) ovr_at = i;
         if (seq_done && done_at < 0) begin
            done_at = i;
            fail_at_done = int'(seq_fail);
         end
      end
      start_req = 1'b0;
      repeat (30) @(negedge clk);
      dones  = mon_dones - d0;
      rises  = mon_rises - r0;
      runbad = mon_runbad - b0;
   endtask

   task automatic t_reset();
      check(scl_drive == 1'b1,    "R1 scl_drive", int'(scl_drive), 1);
      check(pin_override == 1'b0, "R1 pin_override", int'(pin_override), 0);
      check(seq_done == 1'b0,     "R1 seq_done", int'(seq_done), 0);
      check(seq_fail == 1'b0,     "R1 seq_fail", int'(seq_fail), 0);
   endtask

   task automatic t_clean(input bit expect_prev_fail);
      int ov, dn, nd, rs, rb, fd, fs;
      bus_busy = 1'b0; slave_hold = 1'b0;
      if (expect_prev_fail)
         check(seq_fail == 1'b1, "R9 fail held before next start", int'(seq_fail), 1);
      run_seq(-1, -1, ov, dn, nd, rs, rb, fd, fs);
      check(ov == -1, "R3 clean no override", ov, -1);
      check(dn == 2,  "R3 clean done cycle", dn, 2);
      check(nd == 1,  "R9 clean single done", nd, 1);
      check(fd == 0,  "R3 clean no fail", fd, 0);
      if (expect_prev_fail)
         check(fs == 0, "R9 fail cleared after start", fs, 0);
   endtask

   task automatic t_busy_clears();
      int ov, dn, nd, rs, rb, fd, fs;
      bus_busy = 1'b1; slave_hold = 1'b0;
      run_seq(-1, 7, ov, dn, nd, rs, rb, fd, fs);
      check(ov == -1, "R3 late idle no override", ov, -1);
      check(dn == 8,  "R3 done one cycle after busy drop", dn, 8);
      check(nd == 1,  "R9 late idle single done", nd, 1);
   endtask

   task automatic t_busy_timeout();
      int ov, dn, nd, rs, rb, fd, fs;
      bus_busy = 1'b1; slave_hold = 1'b0;
      run_seq(-1, -1, ov, dn, nd, rs, rb, fd, fs);
      bus_busy = 1'b0;
      check(ov == IDLE + 1,          "R4 timeout override cycle", ov, IDLE + 1);
      check(rs - 1 == 0,             "R6 timeout zero pulses with SDA high", rs - 1, 0);
      check(dn == ov + 2 * HALF,     "R8 timeout done cycle", dn, ov + 2 * HALF);
      check(rb == 0,                 "R5 half-period lengths", rb, 0);
      check(fd == 0,                 "R7 timeout no fail", fd, 0);
   endtask

   task automatic t_stuck_release(input int k);
      int ov, dn, nd, rs, rb, fd, fs;
      bus_busy = 1'b0;
      rel_target = mon_rises + k;
      slave_hold = 1'b1;
      repeat (5) @(negedge clk);
      run_seq(-1, -1, ov, dn, nd, rs, rb, fd, fs);
      slave_hold = 1'b0;
      check(ov == 2,                       "R4 stuck SDA override cycle", ov, 2);
      check(rs - 1 == k,                   "R6 pulses until release", rs - 1, k);
      check(rb == 0,                       "R6 high/low half-period lengths", rb, 0);
      check(dn == ov + HALF * (2 * k + 2), "R8 release done cycle", dn, ov + HALF * (2 * k + 2));
      check(fd == 0,                       "R7 released no fail", fd, 0);
   endtask

   task automatic t_stuck_forever();
      int ov, dn, nd, rs, rb, fd, fs;
      bus_busy = 1'b0;
      rel_target = 1 << 30;
      slave_hold = 1'b1;
      repeat (5) @(negedge clk);
      run_seq(40, -1, ov, dn, nd, rs, rb, fd, fs);
      slave_hold = 1'b0;
      check(rs - 1 == MAXP,                   "R7 pulse limit", rs - 1, MAXP);
      check(fd == 1,                          "R7 fail with done", fd, 1);
      check(dn == ov + HALF * (2 * MAXP + 2), "R8 limit done cycle", dn, ov + HALF * (2 * MAXP + 2));
      check(rb == 0,                          "R5 limit half-period lengths", rb, 0);
      check(nd == 1,                          "R2 start during run ignored", nd, 1);
      check(pin_override == 1'b0,             "R2 no second sequence", int'(pin_override), 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 50000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_clean(1'b0);
      t_busy_clears();
      t_busy_timeout();
      t_stuck_release(1);
      t_stuck_release(3);
      t_stuck_forever();
      t_clean(1'b1);
      check(mon_sclbad == 0, "R10 SCL high while released", mon_sclbad, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule